// File: doc/BRIEF.md
# Latch-or-Register Bus Holding Stage

This block sits between an 18-bit input bus and an 18-bit output bus. It holds one data word. A shared mode control selects how it behaves. With the mode control high, the stage is a transparent latch and the output follows the input directly. With the mode control low, the stage is an edge-triggered register. The register loads on each rising edge of a slow bus clock and holds the word between edges. A shared, active-high disable control puts the output into the high-impedance state. The state is shown as a cleared valid flag beside the data, so the block stays synthesizable.

All inputs are sampled by a fast system clock, `clk`. The bus clock is treated as a data input, and its rising edges are found by comparing two successive samples of it. The output bus has no ready signal and applies no back-pressure. `y_vld` is a plain qualifier that tells a downstream stage whether the bus is being driven. A downstream stage that cannot accept a word simply ignores it. The block keeps presenting its held word until that word changes. A synchronous reset clears the held word.

Top module: `bus_hold_stage`

## Requirements
- R1: All 18 data bits behave identically and are governed together by the single `hold_n`, `bus_clk` and `out_dis` controls. An all-ones word and an alternating-bit word pass through unchanged.
- R2: While `out_dis` is 1, `y_vld` is 0 and `y_data` is all zeros in the same cycle, whatever the other inputs are.
- R3: While `hold_n` is 1 and `out_dis` is 0, `y_data` equals `a` combinationally in the same cycle, with no dependence on `bus_clk`.
- R4: A bus-clock rising edge occurs when `bus_clk` is sampled 1 at system edge k after being sampled 0 at edge k-1. The word on `a` at edge k is stored at edge k+1 if `hold_n` is 0 at that edge. It then appears on `y_data` while `hold_n` is 0.
- R5: While `hold_n` is 0 and no bus-clock rising edge is being acted on, the held word does not change. This holds whether `bus_clk` stays high or stays low, and whatever `a` does.
- R6: While `hold_n` is 1, the held word is loaded from `a` at every system edge. When `hold_n` falls to 0, the output keeps the last `a` value that was present while `hold_n` was 1.
- R7: Asserting `out_dis` does not alter the held word. Once `out_dis` returns to 0 with `hold_n` still 0, `y_data` shows the word held before the disable, even if `a` changed meanwhile.
- R8: While `rst` is 1 at a system edge, the held word is cleared to zero. After reset, with `hold_n` 0 and `out_dis` 0, `y_data` is 0 and `y_vld` is 1.
- R9: Bus-clock rising edges that occur and are consumed while `hold_n` is 1 leave no trace once the block is holding. The word held after `hold_n` falls is the last transparent word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 18 | Input data bus |
| hold_n | input | 1 | 1 = transparent latch, 0 = edge-triggered hold |
| bus_clk | input | 1 | Bus clock, sampled as data |
| out_dis | input | 1 | 1 = output bus released (high impedance) |
| y_data | output | 18 | Output data, zero while released |
| y_vld | output | 1 | 1 = output bus driven |

## Verification
The bench goes after several corner cases.

- **Mode-control fall.** If the held word were not tracking `a` during transparency, the output would jump to a stale word when the mode control falls.
- **Edge window.** An edge detector that acted on bus-clock edges regardless of mode, or that paired the edge with the wrong `a` sample, would store a word one cycle early or late.
- **Disable window.** A design that let the disable gate the storage would come back from a disable showing the wrong word.
- **Steady bus clock.** Long runs with the bus clock held high or held low, and `a` changing, catch a level-triggered load.
- **Random mix.** Random mixes of all four controls cover the combinations between these cases.

// File: rtl/bhs_pkg.sv
package bhs_pkg;
  localparam int unsigned BHS_WIDTH = 18;

  typedef enum logic {
    MODE_HOLD  = 1'b0,
    MODE_TRANS = 1'b1
  } bhs_mode_e;
endpackage

// File: rtl/bhs_edge_detect.sv
module bhs_edge_detect #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_clk,
  input  logic [W-1:0] a,
  output logic         rise,
  output logic [W-1:0] a_smp
);
  logic smp_now;
  logic smp_prev;

  // sample the bus clock and the data word together so they stay aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_now  <= 1'b0;
      smp_prev <= 1'b0;
      a_smp    <= '0;
    end else begin
      smp_now  <= bus_clk;
      smp_prev <= smp_now;
      a_smp    <= a;
    end
  end

  assign rise = smp_now & ~smp_prev;
endmodule

// File: rtl/bhs_cell.sv
module bhs_cell (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic rise,
  input  logic d_now,
  input  logic d_smp,
  output logic q
);
  import bhs_pkg::*;

  logic q_next;

  always_comb begin
    q_next = q;
    if (bhs_mode_e'(mode) == MODE_TRANS) q_next = d_now;
    else if (rise)                      q_next = d_smp;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end
endmodule

// File: rtl/bhs_out_stage.sv
module bhs_out_stage #(
  parameter int unsigned W = 18
) (
  input  logic         mode,
  input  logic         out_dis,
  input  logic [W-1:0] a,
  input  logic [W-1:0] held,
  output logic [W-1:0] y_data,
  output logic         y_vld
);
  logic [W-1:0] sel;

  assign sel    = mode ? a : held;
  assign y_data = out_dis ? '0 : sel;
  assign y_vld  = ~out_dis;
endmodule

// File: rtl/bus_hold_stage.sv
module bus_hold_stage #(
  parameter int unsigned WIDTH = bhs_pkg::BHS_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic             hold_n,
  input  logic             bus_clk,
  input  logic             out_dis,
  output logic [WIDTH-1:0] y_data,
  output logic             y_vld
);
  logic             clk_rise;
  logic [WIDTH-1:0] a_smp;
  logic [WIDTH-1:0] held_word;

  bhs_edge_detect #(.W(WIDTH)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .bus_clk (bus_clk),
    .a       (a),
    .rise    (clk_rise),
    .a_smp   (a_smp)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    bhs_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .mode  (hold_n),
      .rise  (clk_rise),
      .d_now (a[i]),
      .d_smp (a_smp[i]),
      .q     (held_word[i])
    );
  end

  bhs_out_stage #(.W(WIDTH)) u_out (
    .mode    (hold_n),
    .out_dis (out_dis),
    .a       (a),
    .held    (held_word),
    .y_data  (y_data),
    .y_vld   (y_vld)
  );
endmodule

// File: rtl/bhs_checker.sv
module bhs_checker #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a,
  input logic         hold_n,
  input logic         out_dis,
  input logic [W-1:0] y_data,
  input logic         y_vld,
  input logic         clk_rise,
  input logic [W-1:0] a_smp,
  input logic [W-1:0] held_word
);
  // R2
  released_bus_chk: assert property (@(posedge clk) disable iff (rst)
    out_dis |-> (!y_vld && y_data == '0));

  // R3
  transparent_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_n && !out_dis) |-> (y_data == a));

  // R4
  edge_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_n && clk_rise) |=> (held_word == $past(a_smp)));

  // R5
  steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_n && !clk_rise) |=> $stable(held_word));

  // R6
  track_while_open_chk: assert property (@(posedge clk) disable iff (rst)
    hold_n |=> (held_word == $past(a)));

  // R7
  held_shown_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_n && !out_dis) |-> (y_data == held_word));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (held_word == '0));
endmodule

bind bus_hold_stage bhs_checker #(.W(WIDTH)) u_bhs_chk (
  .clk       (clk),
  .rst       (rst),
  .a         (a),
  .hold_n    (hold_n),
  .out_dis   (out_dis),
  .y_data    (y_data),
  .y_vld     (y_vld),
  .clk_rise  (clk_rise),
  .a_smp     (a_smp),
  .held_word (held_word)
);

// File: tb/bus_hold_stage_test.sv
`timescale 1ns/1ps
module bus_hold_stage_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a;
  logic         hold_n;
  logic         bus_clk;
  logic         out_dis;
  logic [W-1:0] y_data;
  logic         y_vld;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state, built from the requirements
  logic [W-1:0] m_held;
  logic [W-1:0] m_asmp;
  logic         m_s0, m_s1;

  always #2 clk = ~clk;

  bus_hold_stage #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .a(a), .hold_n(hold_n),
    .bus_clk(bus_clk), .out_dis(out_dis),
    .y_data(y_data), .y_vld(y_vld)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_held <= '0; m_asmp <= '0; m_s0 <= 1'b0; m_s1 <= 1'b0;
    end else begin
      if (hold_n)              m_held <= a;        // R6
      else if (m_s0 && !m_s1)  m_held <= m_asmp;   // R4
      m_s0   <= bus_clk;
      m_s1   <= m_s0;
      m_asmp <= a;
    end
  end

  function automatic logic [W-1:0] exp_data(logic dis, logic hn,
                                            logic [W-1:0] av,
                                            logic [W-1:0] hv);
    if (dis)     return '0;
    else if (hn) return av;
    else         return hv;
  endfunction

  task automatic check(string tag, logic [W-1:0] exp_d, logic exp_v);
    total++;
    if (y_data !== exp_d || y_vld !== exp_v) begin
      bad++;
      $display("FAIL %s: y_data=%h y_vld=%b expected y_data=%h y_vld=%b",
               tag, y_data, y_vld, exp_d, exp_v);
    end
  endtask

  task automatic step(logic [W-1:0] av, logic hn, logic bc, logic dis,
                      string tag);
    @(negedge clk);
    a = av; hold_n = hn; bus_clk = bc; out_dis = dis;
    #1;
    check(tag, exp_data(out_dis, hold_n, a, m_held), ~out_dis);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1BAD5EED));
    rst = 1'b1; a = '1; hold_n = 1'b0; bus_clk = 1'b0; out_dis = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R8: held word cleared by reset
    check("R8 reset", '0, 1'b1);
    step(18'h15555, 1'b0, 1'b0, 1'b0, "R8 post-reset hold");
    check("R8 literal", '0, 1'b1);

    // R1: wide patterns through transparent mode
    step(18'h3FFFF, 1'b1, 1'b0, 1'b0, "R1 ones");
    check("R1 ones literal", 18'h3FFFF, 1'b1);
    step(18'h2AAAA, 1'b1, 1'b1, 1'b0, "R1 alt");
    check("R1 alt literal", 18'h2AAAA, 1'b1);

    // R6/R9: edges while transparent, then close
    step(18'h01234, 1'b1, 1'b0, 1'b0, "R9 open");
    step(18'h04321, 1'b1, 1'b1, 1'b0, "R9 edge while open");
    step(18'h0ABCD, 1'b0, 1'b1, 1'b0, "R6 close");
    check("R6 literal", 18'h04321, 1'b1);
    step(18'h11111, 1'b0, 1'b1, 1'b0, "R9 hold");
    check("R9 literal", 18'h04321, 1'b1);

    // R5: bus clock steady high, then low, a wandering
    for (int i = 0; i < 4; i++) step(W'($urandom), 1'b0, 1'b1, 1'b0, "R5 high");
    for (int i = 0; i < 4; i++) step(W'($urandom), 1'b0, 1'b0, 1'b0, "R5 low");
    check("R5 literal", 18'h04321, 1'b1);

    // R4: edge stores the word present at the high sample
    step(18'h0BEEF, 1'b0, 1'b1, 1'b0, "R4 edge");
    step(18'h05A5A, 1'b0, 1'b1, 1'b0, "R4 load");
    step(18'h00F0F, 1'b0, 1'b1, 1'b0, "R4 shown");
    check("R4 literal", 18'h0BEEF, 1'b1);

    // R7: disable leaves held word alone
    step(18'h12345, 1'b0, 1'b0, 1'b1, "R7 off");
    step(18'h2FFFF, 1'b0, 1'b0, 1'b1, "R2 off");
    step(18'h00001, 1'b0, 1'b0, 1'b0, "R7 back on");
    check("R7 literal", 18'h0BEEF, 1'b1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic hn, dis, bc;
      hn  = ($urandom % 4) == 0;
      dis = ($urandom % 6) == 0;
      bc  = (($urandom % 3) == 0) ? ~bus_clk : bus_clk;
      step(W'($urandom), hn, bc, dis,
           dis ? "R2 random" : (hn ? "R3 random" : "R4 random"));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule